// File: doc/BRIEF.md
# Gray-Coded Multi-Bit Control Crossing

This block carries a multi-bit control value, such as a counter or a state number, from a source clock domain into a destination clock domain that has no fixed phase relation to it. In the source domain the binary value is converted to Gray code and captured in a register. Each bit of that registered Gray word then goes through its own chain of flip-flops clocked by the destination clock. Only after the last stage is the word converted back to binary and registered as the destination output.

Each legal step of the source value, one count up or one count down including wrap-around, changes exactly one Gray bit. A destination flop that samples during that change therefore sees either the old value or the new one, and never a mix of the two. A monitor in the source domain compares each newly registered Gray word with the one before it. If more than one bit changed, it raises an error flag that stays set until the source reset. Each domain has its own asynchronous active-low reset.

Top module: `gray_xing`

## Requirements
- R1: While both resets are asserted and right after they are released, with the source input held at 0, `dst_val` reads 0 and `src_err` reads 0.
- R2: When the source counts up one step at a time, holding each value at least 10 source cycles, `dst_val` takes every value in order and takes no other value.
- R3: Counting down one step at a time, including the wrap from 0 to 2^W-1, is delivered in order in the same way as R2.
- R4: The up-count wrap from 2^W-1 to 0 is a single-bit Gray step. It is delivered to `dst_val` and does not set `src_err`.
- R5: A value applied at `src_val` appears at `dst_val` within one source clock period plus M+2 destination clock periods. While the last synchronizer stage is unchanged for a destination cycle, `dst_val` does not change on the next edge.
- R6: A source cycle whose registered Gray word equals the previous word, or differs from it in one bit, does not set `src_err`.
- R7: On the first source clock edge that registers a Gray word differing from the previous registered word in two or more bits, `src_err` becomes 1. It then stays 1 until the source reset, even through later legal steps. The registered word after source reset is the Gray code of 0.
- R8: Asserting `src_rst_n` low clears `src_err`. After release, legal steps leave it at 0.
- R9: Asserting `dst_rst_n` low forces `dst_val` to 0 and leaves `src_err` unchanged. After release, `dst_val` returns to the value held at the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_val | input | W | Binary control value in the source domain |
| src_err | output | 1 | Sticky flag: a registered Gray step changed more than one bit |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_val | output | W | Binary value recovered in the destination domain |

## Verification
The bench runs a full up-count with wrap-around and a full down-count with wrap-around, using source and destination clocks whose edges drift against each other. This separates an encoder or decoder that is correct only in one direction or only away from the wrap point from one that is correct everywhere. A long hold at one value shows that a cycle with no change is not counted as a violation. A deliberate three-bit jump followed by legal steps separates a sticky flag from one that clears itself, and resetting each domain on its own shows that each reset reaches only its own side.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int unsigned GX_DEF_W = 4;
  localparam int unsigned GX_DEF_M = 2;

  // classification of one registered Gray step
  typedef enum logic [1:0] {
    GX_HOLD = 2'd0,
    GX_STEP = 2'd1,
    GX_JUMP = 2'd2
  } gx_step_e;
endpackage

// File: rtl/gx_src_enc.sv
module gx_src_enc
  import gx_pkg::*;
#(
  parameter int unsigned W = GX_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o,
  output logic         err_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  gray_d, gray_q;
  logic [W-1:0]  diff;
  logic [CW-1:0] nflip;
  gx_step_e      kind;
  logic          err_d, err_q;

  always_comb begin
    gray_d = bin_i ^ (bin_i >> 1);
    diff   = gray_d ^ gray_q;
    nflip  = '0;
    for (int i = 0; i < W; i++) begin
      nflip = nflip + CW'(diff[i]);
    end
    if (nflip == '0)          kind = GX_HOLD;
    else if (nflip == CW'(1)) kind = GX_STEP;
    else                      kind = GX_JUMP;
    err_d = err_q | (kind == GX_JUMP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q <= '0;
      err_q  <= 1'b0;
    end else begin
      gray_q <= gray_d;
      err_q  <= err_d;
    end
  end

  assign gray_o = gray_q;
  assign err_o  = err_q;
endmodule

// File: rtl/gx_sync_bit.sv
module gx_sync_bit
  import gx_pkg::*;
#(
  parameter int unsigned M = GX_DEF_M
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [M-1:0] chain_d, chain_q;

  always_comb begin
    chain_d = {chain_q[M-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[M-1];
endmodule

// File: rtl/gx_dst_dec.sv
module gx_dst_dec
  import gx_pkg::*;
#(
  parameter int unsigned W = GX_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] bin_d, bin_q;

  always_comb begin
    bin_d[W-1] = gray_i[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_d[i] = bin_d[i+1] ^ gray_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_q <= '0;
    else        bin_q <= bin_d;
  end

  assign bin_o = bin_q;
endmodule

// File: rtl/gray_xing.sv
module gray_xing
  import gx_pkg::*;
#(
  parameter int unsigned W = GX_DEF_W,
  parameter int unsigned M = GX_DEF_M
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_val,
  output logic         src_err,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_val
);
  logic [W-1:0] src_gray;
  logic [W-1:0] sync_q;

  gx_src_enc #(.W(W)) u_enc (
    .clk    (src_clk),
    .rst_n  (src_rst_n),
    .bin_i  (src_val),
    .gray_o (src_gray),
    .err_o  (src_err)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    gx_sync_bit #(.M(M)) u_sync (
      .clk   (dst_clk),
      .rst_n (dst_rst_n),
      .d     (src_gray[b]),
      .q     (sync_q[b])
    );
  end

  gx_dst_dec #(.W(W)) u_dec (
    .clk    (dst_clk),
    .rst_n  (dst_rst_n),
    .gray_i (sync_q),
    .bin_o  (dst_val)
  );
endmodule

// File: rtl/gray_xing_chk.sv
module gray_xing_chk #(
  parameter int unsigned W = 4
) (
  input logic         src_clk,
  input logic         src_rst_n,
  input logic         src_err,
  input logic [W-1:0] src_gray,
  input logic         dst_clk,
  input logic         dst_rst_n,
  input logic [W-1:0] sync_q,
  input logic [W-1:0] dst_val
);
  AST_ERR_STICKY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_err |=> src_err); // R7

  AST_ERR_NEEDS_JUMP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(src_err) |-> ($countones(src_gray ^ $past(src_gray)) > 1)); // R7

  AST_SMALL_STEP_CLEAN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (($countones(src_gray ^ $past(src_gray)) <= 1) && !$past(src_err)) |-> !src_err); // R6

  AST_OUT_FOLLOWS_SYNC: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $stable(sync_q) |=> $stable(dst_val)); // R5

  always @(posedge src_clk) begin
    if (!src_rst_n) begin
      AST_ERR_CLEAR_IN_RESET: assert (!src_err); // R8
    end
  end
endmodule

bind gray_xing gray_xing_chk #(.W(W)) u_chk (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n),
  .src_err   (src_err),
  .src_gray  (src_gray),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n),
  .sync_q    (sync_q),
  .dst_val   (dst_val)
);

// File: tb/gray_xing_bench.sv
`timescale 1ns/1ps
module gray_xing_bench;
  localparam int W    = 4;
  localparam int M    = 2;
  localparam int TOP  = (1 << W) - 1;
  localparam int HOLD = 10;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst_n;
  logic         dst_rst_n;
  logic [W-1:0] src_val;
  logic         src_err;
  logic [W-1:0] dst_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int           exp_q[$];
  bit           mon_en = 1'b0;
  logic [W-1:0] last_seen = '0;

  always #2   src_clk = ~src_clk;   // 250 MHz
  always #3.5 dst_clk = ~dst_clk;

  gray_xing #(.W(W), .M(M)) u_gray_xing (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_val   (src_val),
    .src_err   (src_err),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_val   (dst_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: every change of dst_val must be the next queued value
  always @(negedge dst_clk) begin
    if (mon_en && dst_rst_n && dst_val !== last_seen) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R3 unexpected value", int'(dst_val), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(dst_val) == e, "R2/R3 order", int'(dst_val), e);
      end
      last_seen = dst_val;
    end
  end

  task automatic mon_restart();
    exp_q.delete();
    last_seen = dst_val;
    mon_en = 1'b1;
  endtask

  // driver: one legal step, push, hold, then check settle and flag
  task automatic step(input int v, input string req);
    @(negedge src_clk);
    if (mon_en) exp_q.push_back(v);
    src_val = W'(v);
    repeat (HOLD) @(negedge src_clk);
    chk(int'(dst_val) == v, {req, " R5 settle"}, int'(dst_val), v);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    src_val   = '0;
    repeat (4) @(negedge src_clk);
    chk(dst_val == '0, "R1 dst in reset", int'(dst_val), 0);
    chk(src_err == 1'b0, "R1 err in reset", int'(src_err), 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (6) @(negedge src_clk);
    chk(dst_val == '0, "R1 dst after reset", int'(dst_val), 0);
    chk(src_err == 1'b0, "R1 err after reset", int'(src_err), 0);

    mon_restart();
    // R2 up count, R4 wrap from top to 0
    for (int v = 1; v <= TOP; v++) step(v, "R2");
    step(0, "R4");
    chk(src_err == 1'b0, "R4 wrap no error", int'(src_err), 0);

    // R6 hold
    repeat (40) @(negedge src_clk);
    chk(src_err == 1'b0, "R6 hold", int'(src_err), 0);
    chk(dst_val == '0, "R6 hold value", int'(dst_val), 0);

    // R3 down count with wrap 0 -> top
    for (int v = TOP; v >= 0; v--) step(v, "R3");
    chk(src_err == 1'b0, "R3 no error", int'(src_err), 0);
    repeat (20) @(negedge dst_clk);
    chk(exp_q.size() == 0, "R2/R3 all delivered", exp_q.size(), 0);

    for (int v = 1; v <= 5; v++) step(v, "R2");
    // R9 destination reset alone
    mon_en = 1'b0;
    @(negedge dst_clk);
    dst_rst_n = 1'b0;
    @(negedge dst_clk);
    chk(dst_val == '0, "R9 dst forced 0", int'(dst_val), 0);
    chk(src_err == 1'b0, "R9 err untouched", int'(src_err), 0);
    dst_rst_n = 1'b1;
    repeat (HOLD) @(negedge src_clk);
    chk(int'(dst_val) == 5, "R9 dst recovers", int'(dst_val), 5);
    step(4, "R9");

    // R7 jump 4 -> 11: gray 0110 -> 1110 is one bit; 4 -> 9: 0110 -> 1101 three bits
    @(negedge src_clk);
    src_val = W'(9);
    @(negedge src_clk);
    chk(src_err == 1'b1, "R7 jump flagged", int'(src_err), 1);
    step(8, "R7");
    step(7, "R7");
    chk(src_err == 1'b1, "R7 sticky", int'(src_err), 1);

    // R8 source reset clears flag; R9 converse: dst output unaffected until source moves
    @(negedge src_clk);
    src_val = '0;
    src_rst_n = 1'b0;
    @(negedge src_clk);
    chk(src_err == 1'b0, "R8 cleared", int'(src_err), 0);
    src_rst_n = 1'b1;
    repeat (HOLD) @(negedge src_clk);
    chk(dst_val == '0, "R8 dst after src reset", int'(dst_val), 0);
    mon_restart();
    step(1, "R8");
    step(2, "R8");
    chk(src_err == 1'b0, "R8 stays clear", int'(src_err), 0);
    repeat (10) @(negedge dst_clk);
    chk(exp_q.size() == 0, "R2 final drain", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule